// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

A bank of fair mutual-exclusion locks. Each lock keeps a pair of 8-bit counters, a dispenser (the next ticket to hand out) and a serving counter (the ticket that currently owns the lock). After reset both are zero. A requester takes a ticket in one atomic fetch-and-increment on the dispenser. It then polls with that ticket until the serving counter reaches it. The owner releases by advancing the serving counter by one. Waiters are admitted strictly in the order their tickets were issued.

Several requester ports share the unit. Takes from different ports to the same lock in one cycle are ordered by port index, lowest first, and receive consecutive tickets. Each take or poll response also carries the modular distance from the serving counter to the ticket. A waiter can scale its backoff by this value instead of backing off exponentially. A release on a lock that nobody holds (serving equal to dispenser) is dropped and flagged.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset every lock has both counters at 0: a poll with ticket 0 is granted with distance 0, the first take returns ticket 0, and no response is valid while reset is asserted.
- R2: A take (op code 0) returns the lock's current dispenser value and advances the dispenser by one, wrapping modulo 256.
- R3: Takes to one lock in the same cycle get distinct consecutive tickets in ascending port-index order, and the dispenser advances by their count.
- R4: The granted flag of a take or poll (op code 1, ticket on the port's ticket input) is 1 exactly when the ticket equals the lock's serving counter at the start of that cycle.
- R5: An accepted release (op code 2) advances the serving counter by one. Several releases to one lock in a cycle are accepted in port order only while the held count (dispenser minus serving, modulo 256) at the start of the cycle is not used up.
- R6: A release beyond the held count changes no counter and returns the error flag 1. All other responses have error 0. A release response has ticket, granted and distance all 0.
- R7: The distance output equals (ticket minus serving) modulo 256. The serving value is the one at the start of the cycle, and the ticket is the issued ticket for a take or the supplied ticket for a poll.
- R8: Lock index (2 bits) selects one of 4 locks, and a request to one lock leaves the other locks' counters unchanged.
- R9: Each response appears one cycle after its request, with its valid bit set exactly for valid requests whose op code is 0, 1 or 2. Op code 3 gives no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_PORTS | Request present, per port |
| req_lock_i | input | NUM_PORTS*2 | Lock index, per port |
| req_op_i | input | NUM_PORTS*2 | 0 take, 1 poll, 2 release, 3 none |
| req_ticket_i | input | NUM_PORTS*8 | Ticket to test on a poll |
| resp_valid_o | output | NUM_PORTS | Response present, per port |
| resp_ticket_o | output | NUM_PORTS*8 | Issued or polled ticket |
| resp_granted_o | output | NUM_PORTS | Ticket currently owns the lock |
| resp_dist_o | output | NUM_PORTS*8 | Ticket minus serving, modulo 256 |
| resp_err_o | output | NUM_PORTS | Release of an unheld lock |

## Verification
The bench targets same-cycle takes on one lock. A design that ranked them wrongly would issue duplicate tickets or skip some, and later polls would either grant two owners or never grant one. It drives bursts of releases larger than the held count. A unit that checked each release against a stale count would let the serving counter run past the dispenser, so a fresh take would be refused its grant and the lock would hang. Long random runs push both counters through the 255-to-0 wrap. There a non-modular distance or compare would report huge distances or miss grants. Requests on neighbouring locks and op code 3 are mixed in to catch cross-lock leakage and spurious responses.

// File: rtl/tkt_pkg.sv
package tkt_pkg;
  typedef enum logic [1:0] {
    OP_TAKE    = 2'd0,
    OP_POLL    = 2'd1,
    OP_RELEASE = 2'd2,
    OP_NONE    = 2'd3
  } tkt_op_e;
endpackage

// File: rtl/tkt_rank.sv
// Per port: how many lower-index ports issue the same op to the same lock.
module tkt_rank import tkt_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int LOCK_W    = 2,
  parameter int CNT_W     = 3
) (
  input  logic [NUM_PORTS-1:0]        valid_i,
  input  logic [NUM_PORTS*LOCK_W-1:0] lock_i,
  input  logic [NUM_PORTS*2-1:0]      op_i,
  output logic [NUM_PORTS*CNT_W-1:0]  take_rank_o,
  output logic [NUM_PORTS*CNT_W-1:0]  rel_rank_o
);
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [CNT_W-1:0] tr, rr;
      tr = '0;
      rr = '0;
      for (int q = 0; q < p; q++) begin
        if (valid_i[q] && lock_i[q*LOCK_W +: LOCK_W] == lock_i[p*LOCK_W +: LOCK_W]) begin
          if (op_i[q*2 +: 2] == OP_TAKE)    tr = tr + CNT_W'(1);
          if (op_i[q*2 +: 2] == OP_RELEASE) rr = rr + CNT_W'(1);
        end
      end
      take_rank_o[p*CNT_W +: CNT_W] = tr;
      rel_rank_o[p*CNT_W +: CNT_W]  = rr;
    end
  end
endmodule

// File: rtl/tkt_lock_bank.sv
module tkt_lock_bank #(
  parameter int NUM_LOCKS = 4,
  parameter int TKT_W     = 8,
  parameter int CNT_W     = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LOCKS*CNT_W-1:0]   take_cnt_i,
  input  logic [NUM_LOCKS*CNT_W-1:0]   rel_cnt_i,
  output logic [NUM_LOCKS*TKT_W-1:0]   next_o,
  output logic [NUM_LOCKS*TKT_W-1:0]   serving_o
);
  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    logic [TKT_W-1:0] next_q, serving_q;
    logic [CNT_W-1:0] tc, rc;
    assign tc = take_cnt_i[l*CNT_W +: CNT_W];
    assign rc = rel_cnt_i[l*CNT_W +: CNT_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        next_q    <= '0;
        serving_q <= '0;
      end else begin
        next_q    <= next_q + TKT_W'(tc);
        serving_q <= serving_q + TKT_W'(rc);
      end
    end

    assign next_o[l*TKT_W +: TKT_W]    = next_q;
    assign serving_o[l*TKT_W +: TKT_W] = serving_q;

    // serving may never pass the dispenser
    assert_no_overtake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      TKT_W'(rc) <= TKT_W'(next_q - serving_q));
  end
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit import tkt_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_LOCKS = 4,
  parameter int TKT_W     = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_PORTS-1:0]               req_valid_i,
  input  logic [NUM_PORTS*$clog2(NUM_LOCKS)-1:0] req_lock_i,
  input  logic [NUM_PORTS*2-1:0]             req_op_i,
  input  logic [NUM_PORTS*TKT_W-1:0]         req_ticket_i,
  output logic [NUM_PORTS-1:0]               resp_valid_o,
  output logic [NUM_PORTS*TKT_W-1:0]         resp_ticket_o,
  output logic [NUM_PORTS-1:0]               resp_granted_o,
  output logic [NUM_PORTS*TKT_W-1:0]         resp_dist_o,
  output logic [NUM_PORTS-1:0]               resp_err_o
);
  localparam int LOCK_W = $clog2(NUM_LOCKS);
  localparam int CNT_W  = $clog2(NUM_PORTS + 1);

  logic [NUM_PORTS*CNT_W-1:0] take_rank, rel_rank;
  logic [NUM_LOCKS*CNT_W-1:0] take_cnt, rel_cnt;
  logic [NUM_LOCKS*TKT_W-1:0] next_flat, serving_flat;

  tkt_rank #(.NUM_PORTS(NUM_PORTS), .LOCK_W(LOCK_W), .CNT_W(CNT_W)) u_rank (
    .valid_i     (req_valid_i),
    .lock_i      (req_lock_i),
    .op_i        (req_op_i),
    .take_rank_o (take_rank),
    .rel_rank_o  (rel_rank)
  );

  tkt_lock_bank #(.NUM_LOCKS(NUM_LOCKS), .TKT_W(TKT_W), .CNT_W(CNT_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_cnt_i (take_cnt),
    .rel_cnt_i  (rel_cnt),
    .next_o     (next_flat),
    .serving_o  (serving_flat)
  );

  logic [NUM_PORTS-1:0]       v_d, g_d, e_d, rel_d;
  logic [NUM_PORTS*TKT_W-1:0] t_d, dist_d;
  logic [NUM_PORTS-1:0]       rel_q;

  always_comb begin
    take_cnt = '0;
    rel_cnt  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [LOCK_W-1:0] lk;
      logic [TKT_W-1:0]  nx, sv, held, tk;
      tkt_op_e           op;
      lk   = req_lock_i[p*LOCK_W +: LOCK_W];
      op   = tkt_op_e'(req_op_i[p*2 +: 2]);
      nx   = next_flat[lk*TKT_W +: TKT_W];
      sv   = serving_flat[lk*TKT_W +: TKT_W];
      held = nx - sv;
      tk   = '0;
      v_d[p]   = req_valid_i[p] && (op != OP_NONE);
      g_d[p]   = 1'b0;
      e_d[p]   = 1'b0;
      rel_d[p] = 1'b0;
      if (req_valid_i[p]) begin
        case (op)
          OP_TAKE: begin
            tk = nx + TKT_W'(take_rank[p*CNT_W +: CNT_W]);
            take_cnt[lk*CNT_W +: CNT_W] = take_cnt[lk*CNT_W +: CNT_W] + CNT_W'(1);
          end
          OP_POLL: tk = req_ticket_i[p*TKT_W +: TKT_W];
          OP_RELEASE: begin
            rel_d[p] = 1'b1;
            if (TKT_W'(rel_rank[p*CNT_W +: CNT_W]) < held)
              rel_cnt[lk*CNT_W +: CNT_W] = rel_cnt[lk*CNT_W +: CNT_W] + CNT_W'(1);
            else
              e_d[p] = 1'b1;
          end
          default: ;
        endcase
      end
      if (req_valid_i[p] && (op == OP_TAKE || op == OP_POLL)) begin
        g_d[p] = (tk == sv);
        dist_d[p*TKT_W +: TKT_W] = tk - sv;
      end else begin
        dist_d[p*TKT_W +: TKT_W] = '0;
      end
      t_d[p*TKT_W +: TKT_W] = tk;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o   <= '0;
      resp_ticket_o  <= '0;
      resp_granted_o <= '0;
      resp_dist_o    <= '0;
      resp_err_o     <= '0;
      rel_q          <= '0;
    end else begin
      resp_valid_o   <= v_d;
      resp_ticket_o  <= t_d;
      resp_granted_o <= g_d;
      resp_dist_o    <= dist_d;
      resp_err_o     <= e_d;
      rel_q          <= rel_d;
    end
  end

  // at most one same-cycle take per lock may land on the serving ticket
  logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] take_grant_m;
  always_comb begin
    take_grant_m = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (req_valid_i[p] && req_op_i[p*2 +: 2] == OP_TAKE && g_d[p])
        take_grant_m[req_lock_i[p*LOCK_W +: LOCK_W]][p] = 1'b1;
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_chk_lock
    assert_single_take_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(take_grant_m[l]));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk_port
    assert_grant_zero_dist_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_o[p] && resp_granted_o[p] |-> resp_dist_o[p*TKT_W +: TKT_W] == '0);
    assert_err_only_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_err_o[p] |-> resp_valid_o[p] && rel_q[p]);
    assert_resp_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i[p] && req_op_i[p*2 +: 2] != OP_NONE |=> resp_valid_o[p]);
  end
endmodule

// File: tb/tb_ticket_lock_unit.sv
module tb_ticket_lock_unit;
  localparam int P = 4, NL = 4, TW = 8, LW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [P-1:0]    req_valid;
  logic [P*LW-1:0] req_lock;
  logic [P*2-1:0]  req_op;
  logic [P*TW-1:0] req_ticket;
  logic [P-1:0]    resp_valid, resp_granted, resp_err;
  logic [P*TW-1:0] resp_ticket, resp_dist;

  ticket_lock_unit #(.NUM_PORTS(P), .NUM_LOCKS(NL), .TKT_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_lock_i(req_lock), .req_op_i(req_op), .req_ticket_i(req_ticket),
    .resp_valid_o(resp_valid), .resp_ticket_o(resp_ticket), .resp_granted_o(resp_granted),
    .resp_dist_o(resp_dist), .resp_err_o(resp_err)
  );

  int checks = 0, fails = 0;
  int m_next[NL], m_serv[NL];
  int rv[P], rl[P], ro[P], rt[P];
  int e_v[P], e_t[P], e_g[P], e_d[P], e_e[P];
  string e_tag[P];
  string force_tag = "";
  bit pend = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tg(string dflt);
    return (force_tag != "") ? force_tag : dflt;
  endfunction

  task automatic check_out();
    for (int p = 0; p < P; p++) begin
      chk(tg("R9"), $sformatf("valid p%0d", p), int'(resp_valid[p]), e_v[p]);
      if (e_v[p] != 0) begin
        chk(tg(e_tag[p]), $sformatf("ticket p%0d", p), int'(resp_ticket[p*TW +: TW]), e_t[p]);
        chk(tg("R4"), $sformatf("granted p%0d", p), int'(resp_granted[p]), e_g[p]);
        chk(tg("R7"), $sformatf("dist p%0d", p), int'(resp_dist[p*TW +: TW]), e_d[p]);
        chk(tg("R6"), $sformatf("err p%0d", p), int'(resp_err[p]), e_e[p]);
      end
    end
  endtask

  task automatic cycle();
    int held[NL], tr[NL], rr[NL], acc[NL], nt[NL];
    @(negedge clk);
    if (pend) check_out();
    for (int l = 0; l < NL; l++) begin
      held[l] = (m_next[l] - m_serv[l] + 256) % 256;
      tr[l] = 0; rr[l] = 0; acc[l] = 0; nt[l] = 0;
    end
    for (int p = 0; p < P; p++)
      if (rv[p] != 0 && ro[p] == 0) nt[rl[p]]++;
    for (int p = 0; p < P; p++) begin
      int l;
      l = rl[p];
      req_valid[p] = (rv[p] != 0);
      req_lock[p*LW +: LW] = LW'(l);
      req_op[p*2 +: 2] = 2'(ro[p]);
      req_ticket[p*TW +: TW] = TW'(rt[p]);
      e_v[p] = (rv[p] != 0 && ro[p] != 3) ? 1 : 0;
      e_t[p] = 0; e_g[p] = 0; e_d[p] = 0; e_e[p] = 0; e_tag[p] = "R2";
      if (e_v[p] != 0) begin
        if (ro[p] == 0) begin
          e_t[p] = (m_next[l] + tr[l]) % 256;
          tr[l]++;
          e_tag[p] = (nt[l] > 1) ? "R3" : "R2";
        end else if (ro[p] == 1) begin
          e_t[p] = rt[p] % 256;
          e_tag[p] = "R4";
        end else begin
          e_tag[p] = "R6";
          if (rr[l] < held[l]) acc[l]++; else e_e[p] = 1;
          rr[l]++;
        end
        if (ro[p] < 2) begin
          e_g[p] = (e_t[p] == m_serv[l]) ? 1 : 0;
          e_d[p] = (e_t[p] - m_serv[l] + 256) % 256;
        end
      end
    end
    for (int l = 0; l < NL; l++) begin
      m_next[l] = (m_next[l] + tr[l]) % 256;
      m_serv[l] = (m_serv[l] + acc[l]) % 256;
    end
    pend = 1;
  endtask

  task automatic idle_all();
    for (int p = 0; p < P; p++) begin rv[p] = 0; rl[p] = 0; ro[p] = 3; rt[p] = 0; end
  endtask

  task automatic set(int p, int l, int o, int t);
    rv[p] = 1; rl[p] = l; ro[p] = o; rt[p] = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    req_valid = '0; req_lock = '0; req_op = '1; req_ticket = '0;
    for (int l = 0; l < NL; l++) begin m_next[l] = 0; m_serv[l] = 0; end
    idle_all();
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(resp_valid), 0);
    rst_n = 1'b1;

    // R1: fresh locks
    force_tag = "R1";
    idle_all();
    for (int p = 0; p < P; p++) set(p, p, 1, 0);
    cycle();
    idle_all(); set(0, 0, 0, 0); cycle();
    // R3: four same-cycle takes on lock 1
    force_tag = "R3";
    idle_all(); for (int p = 0; p < P; p++) set(p, 1, 0, 0); cycle();
    // R8: lock 2 untouched by activity on locks 0 and 1
    force_tag = "R8";
    idle_all(); set(0, 2, 1, 0); set(1, 2, 0, 0); set(2, 1, 1, 0); set(3, 1, 1, 2); cycle();
    // R6: three releases on lock 0 with one holder
    force_tag = "R6";
    idle_all(); set(0, 0, 2, 0); set(1, 0, 2, 0); set(2, 0, 2, 0); set(3, 3, 2, 0); cycle();
    // R5: serving of lock 0 advanced by exactly one; release two of lock 1
    force_tag = "R5";
    idle_all(); set(0, 0, 1, 1); set(1, 0, 1, 0); set(2, 1, 2, 0); set(3, 1, 2, 0); cycle();
    idle_all(); set(0, 1, 1, 2); set(1, 1, 1, 3); cycle();
    // R9: op 3 gives nothing and changes nothing
    force_tag = "R9";
    idle_all(); for (int p = 0; p < P; p++) begin set(p, p, 3, 0); end cycle();
    idle_all(); set(0, 1, 1, 2); set(1, 3, 0, 0); cycle();
    // R2/R4/R7 and wrap: random traffic
    force_tag = "";
    for (int i = 0; i < 4000; i++) begin
      idle_all();
      for (int p = 0; p < P; p++) begin
        int r, l;
        r = int'($urandom % 8);
        l = int'($urandom % NL);
        rv[p] = ($urandom % 4 != 0) ? 1 : 0;
        rl[p] = l;
        ro[p] = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
        rt[p] = (m_serv[l] + int'($urandom % 4) + 254) % 256;
      end
      cycle();
    end
    idle_all(); cycle();
    idle_all(); cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule